// File: doc/BRIEF.md
# Packed-Parameter Raster Timing Generator

This block produces the horizontal and vertical timing of a raster display. A host configures it through an 8-bit write path with two ports: a command port and a parameter port. A command byte of 0x00 on the command port opens a setup sequence. The eight parameter bytes that follow carry, in packed form, the mode value and the sync, porch and active sizes of both axes. The block decodes these bytes and then runs two counters. The horizontal counter advances one 4-pixel word per clock. The vertical counter advances one line at the end of each horizontal line.

The encoding uses different offsets on the two axes. Horizontal sizes are stored reduced by one, and the active word count is stored reduced by two. Vertical sizes are stored at face value, so a vertical phase can have zero length. The vertical sync width is split across two bytes. Until the first complete set of parameters has been received, the display stays blanked and both syncs stay low. Once the display is running, a new set takes effect only at the next frame boundary, so a frame is never cut short by reconfiguration.

The outputs are the two sync signals, the two blank flags, a combined blank, display enable, a drawing-permitted flag, and the word and line offsets inside the active area. The horizontal blank and vertical sync outputs double as status flags for the host.

Top module: `crt_timing_gen`

## Requirements
- R1: After reset, and until a complete parameter set has been received, hsync and vsync are 0, hblank, vblank and blank are 1, de is 0, draw_ok is 1, and word_pos and line_pos are 0.
- R2: A write with wr_cmd=1 and data 0x00 starts a setup sequence, and the next eight writes with wr_cmd=0 are taken as parameter bytes 0 to 7. A parameter write outside a sequence is ignored. Any other command byte abandons an unfinished sequence.
- R3: The horizontal sizes, in words, are decoded as follows. Sync = byte2[4:0]+1. Back porch = byte4[5:0]+1. Active = byte1+2. Front porch = byte3[7:2]+1.
- R4: The vertical sizes, in lines, are decoded as follows. Sync = {byte3[1:0], byte2[7:5]}. Back porch = byte7[7:2]. Active = {byte7[1:0], byte6}. Front porch = byte5[5:0]. A vertical phase of length zero is skipped.
- R5: Each line runs sync, back porch, active, then front porch, one word per clock. hsync is 1 only during the sync phase, and hblank is 0 only during the active phase.
- R6: Each frame runs the vertical phases in the same order, advancing one line after the last word of each line. vsync is 1 only during vertical sync, and vblank is 0 only during vertical active.
- R7: blank is the OR of hblank and vblank, and de is its inverse.
- R8: word_pos gives the offset of the current word within the horizontal active phase, and line_pos gives the offset of the current line within the vertical active phase. Each is 0 outside its active phase.
- R9: When bit 4 of parameter byte 0 is set, draw_ok equals blank. When that bit is clear, draw_ok is 1.
- R10: The first parameter set starts the display at the word and line origin one clock after its last byte is written. A later set takes effect only on the clock that ends the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, one horizontal word per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_cmd | input | 1 | 1 selects the command port, 0 selects the parameter port |
| wr_data | input | 8 | Write data byte |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high (status flag) |
| hblank | output | 1 | Horizontal blanking (status flag) |
| vblank | output | 1 | Vertical blanking |
| blank | output | 1 | Combined blanking |
| de | output | 1 | Display enable |
| draw_ok | output | 1 | Drawing permitted under the mode bit |
| word_pos | output | 9 | Word offset within the active line |
| line_pos | output | 10 | Line offset within the active frame |

## Verification
The field widths are fixed by the byte format, so the bench uses the default build. It keeps the design small by choosing parameter bytes instead. One set gives a 7-word by 7-line frame, which a reference model sweeps cycle by cycle over several frames. A second set has zero-length vertical sync, back porch and front porch, and it is loaded mid-frame to exercise the deferred switch at the frame boundary. A third set uses the largest horizontal back porch and a 31-line vertical sync split across two bytes, and it is swept over two full frames. Before any of these, aborted, partial and stray parameter writes are sent to show that none of them starts the display.

// File: rtl/crt_timing_pkg.sv
// Package: shared widths, the decoded timing record, and the byte decoder.
// Assumes the eight-byte packed format listed in the brief (R3, R4).
package crt_timing_pkg;

    localparam int N_PARAM_BYTES = 8;
    // Horizontal total is at most 32+64+257+64 = 417 words.
    localparam int HCW = 9;
    // Vertical total is at most 31+63+1023+63 = 1180 lines.
    localparam int VCW = 11;
    localparam int WPW = 9;
    localparam int LPW = 10;

    typedef logic [N_PARAM_BYTES-1:0][7:0] param_bytes_t;

    typedef struct packed {
        logic [7:0]     mode;
        logic [HCW-1:0] h_sync;
        logic [HCW-1:0] h_back;
        logic [HCW-1:0] h_act;
        logic [HCW-1:0] h_front;
        logic [VCW-1:0] v_sync;
        logic [VCW-1:0] v_back;
        logic [VCW-1:0] v_act;
        logic [VCW-1:0] v_front;
    } timing_t;

    // Undo the per-axis biasing and reassemble the split fields.
    function automatic timing_t unpack_cfg(input param_bytes_t b);
        timing_t t;
        t.mode    = b[0];
        t.h_sync  = HCW'(b[2][4:0]) + HCW'(1);
        t.h_back  = HCW'(b[4][5:0]) + HCW'(1);
        t.h_act   = HCW'(b[1])      + HCW'(2);
        t.h_front = HCW'(b[3][7:2]) + HCW'(1);
        t.v_sync  = VCW'({b[3][1:0], b[2][7:5]});
        t.v_back  = VCW'(b[7][7:2]);
        t.v_act   = VCW'({b[7][1:0], b[6]});
        t.v_front = VCW'(b[5][5:0]);
        return t;
    endfunction

endpackage

// File: rtl/crt_param_capture.sv
// Module: crt_param_capture
// Collects the parameter bytes that follow the start command into a staging
// array. Once the last byte arrives, it copies the whole set into a shadow
// copy and raises pending until the consumer takes it.
// Assumes single-cycle write strobes, with no back-pressure at the host side.
module crt_param_capture #(
    parameter int         NBYTES     = 8,
    parameter logic [7:0] START_CODE = 8'h00
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_cmd,
    input  logic [7:0]             wr_data,
    input  logic                   take,
    output logic [NBYTES-1:0][7:0] shadow,
    output logic                   pending
);
    localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NBYTES - 1);

    logic                   collecting;
    logic [IW-1:0]          idx;
    logic [NBYTES-1:0][7:0] stage;
    logic [NBYTES-1:0][7:0] stage_nxt;
    logic                   byte_wr;
    logic                   complete;

    assign byte_wr  = wr_en && !wr_cmd && collecting;
    assign complete = byte_wr && (idx == LAST_IDX);

    // Staging image with the incoming byte already placed at its slot.
    always_comb begin
        stage_nxt      = stage;
        stage_nxt[idx] = wr_data;
    end

    // Sequence tracking: open on the start code, abandon on any other command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            collecting <= 1'b0;
            idx        <= '0;
        end else if (wr_en && wr_cmd) begin
            collecting <= (wr_data == START_CODE);
            idx        <= '0;
        end else if (byte_wr) begin
            if (complete) begin
                collecting <= 1'b0;
                idx        <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // Byte storage: fill the staging array, and copy it on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage  <= '0;
            shadow <= '0;
        end else if (byte_wr) begin
            stage <= stage_nxt;
            if (complete) begin
                shadow <= stage_nxt;
            end
        end
    end

    // Pending flag: a newly completed set takes priority over consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (complete) begin
            pending <= 1'b1;
        end else if (take) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/crt_axis_counter.sv
// Module: crt_axis_counter
// One timing axis: a position counter that walks sync, back porch, active
// and front porch in turn, then wraps. Phases of length zero are skipped.
// Assumes the sum of the four lengths fits in CW bits.
module crt_axis_counter #(
    parameter int CW = 9,
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] len_sync,
    input  logic [CW-1:0] len_back,
    input  logic [CW-1:0] len_act,
    input  logic [CW-1:0] len_front,
    output logic          last,
    output logic          in_sync,
    output logic          in_act,
    output logic [PW-1:0] rel
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] end_sync;
    logic [CW-1:0] end_back;
    logic [CW-1:0] end_act;
    logic [CW-1:0] total;

    // Phase boundaries, as cumulative sums of the lengths.
    always_comb begin
        end_sync = len_sync;
        end_back = len_sync + len_back;
        end_act  = end_back + len_act;
        total    = end_act + len_front;
    end

    // Position decode against the phase boundaries.
    always_comb begin
        last    = (total == '0) || (cnt == total - 1'b1);
        in_sync = cnt < end_sync;
        in_act  = (cnt >= end_back) && (cnt < end_act);
        rel     = in_act ? PW'(cnt - end_back) : '0;
    end

    // Position register: clear to the origin, step, and wrap after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/crt_timing_gen.sv
// Module: crt_timing_gen (top)
// Raster timing generator configured by the packed parameter bytes of a
// setup command. Holds the decoded timing and loads a new set only when the
// display is idle or at the end of a frame. Drives two axis counters, one
// word per clock horizontally and one line per completed line vertically.
// Assumes one clock per 4-pixel word, with the host writing through
// single-cycle strobes.
module crt_timing_gen #(
    parameter logic [7:0] START_CODE  = 8'h00,
    parameter int         INHIBIT_BIT = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic                             wr_cmd,
    input  logic [7:0]                       wr_data,
    output logic                             hsync,
    output logic                             vsync,
    output logic                             hblank,
    output logic                             vblank,
    output logic                             blank,
    output logic                             de,
    output logic                             draw_ok,
    output logic [crt_timing_pkg::WPW-1:0]   word_pos,
    output logic [crt_timing_pkg::LPW-1:0]   line_pos
);
    import crt_timing_pkg::*;

    param_bytes_t shadow;
    logic         pending;
    logic         take;
    logic         live;
    timing_t      cfg_q;
    logic         h_last, h_sync_ph, h_act_ph;
    logic         v_last, v_sync_ph, v_act_ph;
    logic [WPW-1:0] h_rel;
    logic [LPW-1:0] v_rel;
    logic         frame_end;
    logic         draw_inhibit;

    crt_param_capture #(
        .NBYTES     (N_PARAM_BYTES),
        .START_CODE (START_CODE)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_cmd  (wr_cmd),
        .wr_data (wr_data),
        .take    (take),
        .shadow  (shadow),
        .pending (pending)
    );

    // A load may happen only when idle, or on the clock that closes a frame.
    assign frame_end = live && h_last && v_last;
    assign take      = pending && (!live || frame_end);

    // Active configuration register and running flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live  <= 1'b0;
            cfg_q <= '0;
        end else if (take) begin
            live  <= 1'b1;
            cfg_q <= unpack_cfg(shadow);
        end
    end

    crt_axis_counter #(.CW(HCW), .PW(WPW)) u_hcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (take),
        .step      (live),
        .len_sync  (cfg_q.h_sync),
        .len_back  (cfg_q.h_back),
        .len_act   (cfg_q.h_act),
        .len_front (cfg_q.h_front),
        .last      (h_last),
        .in_sync   (h_sync_ph),
        .in_act    (h_act_ph),
        .rel       (h_rel)
    );

    crt_axis_counter #(.CW(VCW), .PW(LPW)) u_vcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (take),
        .step      (live && h_last),
        .len_sync  (cfg_q.v_sync),
        .len_back  (cfg_q.v_back),
        .len_act   (cfg_q.v_act),
        .len_front (cfg_q.v_front),
        .last      (v_last),
        .in_sync   (v_sync_ph),
        .in_act    (v_act_ph),
        .rel       (v_rel)
    );

    assign draw_inhibit = cfg_q.mode[INHIBIT_BIT];

    // Output shaping: quiet until configured, then decoded from the counters.
    always_comb begin
        hsync    = live && h_sync_ph;
        vsync    = live && v_sync_ph;
        hblank   = !(live && h_act_ph);
        vblank   = !(live && v_act_ph);
        blank    = hblank || vblank;
        de       = !blank;
        draw_ok  = !draw_inhibit || blank;
        word_pos = live ? h_rel : '0;
        line_pos = live ? v_rel : '0;
    end

endmodule

// File: rtl/crt_timing_gen_chk.sv
// Module: crt_timing_gen_chk
// Temporal checks on the timing generator, attached through bind.
module crt_timing_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       live,
    input logic       h_last,
    input logic       draw_inhibit,
    input logic       hsync,
    input logic       vsync,
    input logic       hblank,
    input logic       vblank,
    input logic       blank,
    input logic       draw_ok,
    input logic [8:0] word_pos,
    input logic [9:0] line_pos
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> (!hsync && !vsync && hblank && vblank && blank)); // R1

    AST_HSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> hblank); // R5

    AST_VSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> vblank); // R6

    AST_LINE_HOLDS_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !h_last) |=> $stable(line_pos)); // R6

    AST_WORD_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !hblank) |=> (hblank || (word_pos == $past(word_pos) + 9'd1))); // R8

    AST_DRAW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (draw_inhibit && !blank) |-> !draw_ok); // R9

endmodule

bind crt_timing_gen crt_timing_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .live         (live),
    .h_last       (h_last),
    .draw_inhibit (draw_inhibit),
    .hsync        (hsync),
    .vsync        (vsync),
    .hblank       (hblank),
    .vblank       (vblank),
    .blank        (blank),
    .draw_ok      (draw_ok),
    .word_pos     (word_pos),
    .line_pos     (line_pos)
);

// File: tb/crt_timing_gen_tb.sv
// Bench: a reference model, advanced at each rising edge and built from the
// requirements, predicts every output. The outputs are compared at each
// falling edge.
module crt_timing_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_cmd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       hsync, vsync, hblank, vblank, blank, de, draw_ok;
    logic [8:0] word_pos;
    logic [9:0] line_pos;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit mon_en   = 1'b0;

    always #10 clk = ~clk;

    crt_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .hblank(hblank),
        .vblank(vblank), .blank(blank), .de(de), .draw_ok(draw_ok),
        .word_pos(word_pos), .line_pos(line_pos)
    );

    // Reference model state.
    int  m_cur[8];
    int  m_sh[8];
    int  m_stg[8];
    bit  m_run, m_pend, m_coll;
    int  m_idx, m_h, m_v;

    function automatic int f_hs(); return (m_cur[2] & 31) + 1; endfunction
    function automatic int f_hb(); return (m_cur[4] & 63) + 1; endfunction
    function automatic int f_ha(); return m_cur[1] + 2; endfunction
    function automatic int f_hf(); return (m_cur[3] >> 2) + 1; endfunction
    function automatic int f_vs(); return ((m_cur[3] & 3) << 3) | (m_cur[2] >> 5); endfunction
    function automatic int f_vb(); return m_cur[7] >> 2; endfunction
    function automatic int f_va(); return ((m_cur[7] & 3) << 8) | m_cur[6]; endfunction
    function automatic int f_vf(); return m_cur[5] & 63; endfunction

    // Model advance: mirrors R2, R3, R4, R6 and R10 at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_pend = 0; m_coll = 0; m_idx = 0; m_h = 0; m_v = 0;
            for (int i = 0; i < 8; i++) begin m_cur[i] = 0; m_sh[i] = 0; m_stg[i] = 0; end
        end else begin
            int ht, vt;
            bit fend;
            ht = f_hs() + f_hb() + f_ha() + f_hf();
            vt = f_vs() + f_vb() + f_va() + f_vf();
            fend = m_run && (m_h == ht - 1) && (m_v == vt - 1);
            if (m_pend && (!m_run || fend)) begin
                for (int i = 0; i < 8; i++) m_cur[i] = m_sh[i];
                m_run = 1; m_pend = 0; m_h = 0; m_v = 0;
            end else if (m_run) begin
                if (m_h == ht - 1) begin
                    m_h = 0;
                    m_v = (m_v == vt - 1) ? 0 : m_v + 1;
                end else begin
                    m_h = m_h + 1;
                end
            end
            if (wr_en && wr_cmd) begin
                m_coll = (wr_data == 8'h00);
                m_idx = 0;
            end else if (wr_en && m_coll) begin
                m_stg[m_idx] = int'(wr_data);
                if (m_idx == 7) begin
                    for (int i = 0; i < 8; i++) m_sh[i] = m_stg[i];
                    m_pend = 1; m_coll = 0; m_idx = 0;
                end else begin
                    m_idx = m_idx + 1;
                end
            end
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, got, exp);
        end
    endtask

    // Compare all outputs with the model prediction at each falling edge.
    always @(negedge clk) begin
        if (mon_en && !done) begin
            int e_hs, e_vs, e_hb, e_vb, e_bl, e_wp, e_lp, e_dr;
            string sfx;
            sfx = m_pend ? " R10" : "";
            if (!m_run) begin
                e_hs = 0; e_vs = 0; e_hb = 1; e_vb = 1; e_wp = 0; e_lp = 0;
            end else begin
                int a0, a1, b0, b1;
                a0 = f_hs() + f_hb(); a1 = a0 + f_ha();
                b0 = f_vs() + f_vb(); b1 = b0 + f_va();
                e_hs = (m_h < f_hs()) ? 1 : 0;
                e_vs = (m_v < f_vs()) ? 1 : 0;
                e_hb = (m_h >= a0 && m_h < a1) ? 0 : 1;
                e_vb = (m_v >= b0 && m_v < b1) ? 0 : 1;
                e_wp = e_hb ? 0 : m_h - a0;
                e_lp = e_vb ? 0 : m_v - b0;
            end
            e_bl = e_hb | e_vb;
            e_dr = ((m_cur[0] & 16) != 0) ? e_bl : 1;
            if (!m_run) begin
                check({"R1", sfx}, {hsync, vsync, hblank, vblank, blank, de, draw_ok}, 7'b0011101);
                check({"R1", sfx}, word_pos + line_pos, 0);
            end else begin
                check({"R3 R5", sfx}, {hsync, hblank}, {e_hs[0], e_hb[0]});
                check({"R4 R6", sfx}, {vsync, vblank}, {e_vs[0], e_vb[0]});
                check({"R7", sfx}, {blank, de}, {e_bl[0], ~e_bl[0]});
                check({"R8", sfx}, word_pos, e_wp);
                check({"R8", sfx}, line_pos, e_lp);
                check({"R9", sfx}, draw_ok, e_dr);
            end
        end
    end

    task automatic wr(input bit cmd, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_cmd = cmd; wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_cfg(input int b0, b1, b2, b3, b4, b5, b6, b7);
        wr(1'b1, 8'h00);
        wr(1'b0, b0); wr(1'b0, b1); wr(1'b0, b2); wr(1'b0, b3);
        wr(1'b0, b4); wr(1'b0, b5); wr(1'b0, b6); wr(1'b0, b7);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;
        // R1: outputs quiet straight after reset.
        @(negedge clk);
        check("R1 reset", {hsync, vsync, blank, de}, 4'b0010);
        // R2: stray parameter writes without a start command.
        for (int i = 0; i < 8; i++) wr(1'b0, 8'h11);
        // R2: an unfinished sequence abandoned by another command.
        wr(1'b1, 8'h00);
        for (int i = 0; i < 4; i++) wr(1'b0, 8'h01);
        wr(1'b1, 8'h6F);
        for (int i = 0; i < 4; i++) wr(1'b0, 8'h01);
        repeat (5) @(negedge clk);
        check("R2 ignored", {blank, hsync, vsync}, 3'b100);
        // Config A: 7x7 frame, drawing inhibited in the active area.
        send_cfg(8'h10, 8'h00, 8'h41, 8'h00, 8'h01, 8'h01, 8'h03, 8'h04);
        @(negedge clk);
        check("R10 origin", {hsync, vsync, word_pos}, {1'b1, 1'b1, 9'd0});
        repeat (150) @(negedge clk);
        // Config B loaded mid-frame: zero-length vertical phases, no inhibit.
        repeat (10) @(negedge clk);
        send_cfg(8'h00, 8'h02, 8'h00, 8'h04, 8'h00, 8'h00, 8'h02, 8'h00);
        repeat (120) @(negedge clk);
        // Config C: split 31-line vsync and the widest horizontal porch.
        send_cfg(8'h12, 8'hFE, 8'hE5, 8'h0B, 8'h3F, 8'h02, 8'h01, 8'h0C);
        repeat (26000) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule